// File: doc/BRIEF.md
# Spread-Spectrum PWM Cycle Timer

This block times the switching cycles of a peak-current-mode power converter from a fast system clock. Each cycle begins with a one-clock start strobe and the gate output going high. The gate then stays high until one of three events ends it: the current comparator reports the peak has been reached, the duty-cycle ceiling is hit, or the cycle ends. Two timing guards shape this. Comparator reports are ignored for a short blanking time after turn-on. Once the gate is on, it stays on for a minimum time.

To spread conducted emissions, the cycle length is not fixed. A slow triangular sweep moves it up and down around the nominal value for the chosen frequency variant. The sweep comes from an up/down step counter. A new cycle length is loaded only when a cycle ends, so no cycle is ever cut short. All timing constants are derived at elaboration from the system clock frequency parameter. With the default 50 MHz clock:

| Variant | Nominal period | Sweep amplitude | Period range | Blanking | Minimum on-time |
|---|---|---|---|---|---|
| Low | 833 clocks | 55 clocks | 778 to 888 clocks | 15 clocks | 20 clocks |
| High | 434 clocks | 30 clocks | 404 to 464 clocks | 15 clocks | 20 clocks |

Top module: `jitter_pwm_gen`

## Requirements
- R1: The nominal period is NOM = floor(CLK_HZ / F). F is 60 kHz when `hi_sel` is 0 and 115 kHz when `hi_sel` is 1. The first cycle after `en` rises lasts exactly NOM clocks.
- R2: A cycle lasts NOM + ((s * DEV) >>> STEP_LOG2) clocks, where s is a triangle step in the range -2^STEP_LOG2 to +2^STEP_LOG2.
  - The step s moves by one every CLK_HZ / (MOD_HZ * 4 * 2^STEP_LOG2) clocks.
  - The sweep amplitude is DEV = floor(NOM * D / F), with D = 4 kHz for the low variant and 8 kHz for the high variant.
  - The sweep visits both ends of the range, and every period stays within NOM +/- DEV.
- R3: The period value is loaded only at a cycle boundary. Consecutive periods therefore differ by no more than the steps taken during one cycle.
- R4: `cycle_start` is high for exactly one clock at the start of every cycle. The gate rises only in that clock.
- R5: The gate is low for on-clock indices at or above floor(P * 80 / 100), where P is the current period. This limit overrides every other rule.
- R6: A comparator pulse during the first LEB = floor(300 ns * CLK_HZ) clocks of a cycle has no effect on the gate.
- R7: Once on, the gate stays high for at least TMIN = floor(400 ns * CLK_HZ) clocks, even if the comparator has tripped.
- R8: A comparator pulse at on-clock index c >= LEB makes the on-time min(max(c + 1, TMIN), duty limit) clocks.
- R9: While `en` is low:
  - the gate and `cycle_start` stay low;
  - the cycle counter and the sweep are held at zero;
  - comparator activity is ignored.
  - When `en` rises, a cycle starts in that same clock.
- R10: `off_time` is always the inverse of `gate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces the gate off |
| hi_sel | input | 1 | Frequency variant select: 0 for low, 1 for high |
| cmp_trip | input | 1 | Peak-current comparator flag |
| gate | output | 1 | Gate-on window |
| cycle_start | output | 1 | One-clock strobe at each period start |
| off_time | output | 1 | High whenever the gate is low |

## Verification
The embedded properties check, on every clock, these invariants:
- each period and sweep step stays inside its allowed range;
- the period only changes at a boundary;
- the start strobe lasts one clock, and the gate rises only with it;
- the minimum on-time is never broken;
- a disabled block keeps its counter at zero.

Some behaviour only the bench scenarios can show:
- the exact on-time that results from a comparator pulse at a chosen index, for each variant;
- a pulse inside the blanking window leaving the on-time unchanged;
- the sweep actually reaching both of its ends;
- the exact first period after enable.

// File: rtl/jitter_pwm_gen.sv
`timescale 1ns/1ps
module jitter_pwm_gen #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int F_LO_HZ    = 60_000,
  parameter int F_HI_HZ    = 115_000,
  parameter int DEV_LO_HZ  = 4_000,
  parameter int DEV_HI_HZ  = 8_000,
  parameter int MOD_HZ     = 250,
  parameter int STEP_LOG2  = 4,
  parameter int DUTY_PCT   = 80,
  parameter int LEB_NS     = 300,
  parameter int TON_MIN_NS = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic hi_sel,
  input  logic cmp_trip,
  output logic gate,
  output logic cycle_start,
  output logic off_time
);
  localparam int NOM_LO   = CLK_HZ / F_LO_HZ;
  localparam int NOM_HI   = CLK_HZ / F_HI_HZ;
  localparam int DEV_LO   = (NOM_LO * DEV_LO_HZ) / F_LO_HZ;
  localparam int DEV_HI   = (NOM_HI * DEV_HI_HZ) / F_HI_HZ;
  localparam int PMAX_LO  = NOM_LO + DEV_LO;
  localparam int PMAX_HI  = NOM_HI + DEV_HI;
  localparam int PER_MAX  = (PMAX_LO > PMAX_HI) ? PMAX_LO : PMAX_HI;
  localparam int CW       = $clog2(PER_MAX + 1);
  localparam int STEPS    = 1 << STEP_LOG2;
  localparam int SW       = STEP_LOG2 + 2;
  localparam int WW       = SW + CW + 1;
  localparam int STEP_RAW = CLK_HZ / (MOD_HZ * 4 * STEPS);
  localparam int STEP_CLKS = (STEP_RAW < 1) ? 1 : STEP_RAW;
  localparam int DW       = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam int LEB_CLKS = (LEB_NS * (CLK_HZ / 1000)) / 1_000_000;
  localparam int TON_CLKS = (TON_MIN_NS * (CLK_HZ / 1000)) / 1_000_000;

  localparam logic [CW-1:0] LEB_C    = CW'(LEB_CLKS);
  localparam logic [CW-1:0] TON_C    = CW'(TON_CLKS);
  localparam logic [DW-1:0] DIV_LAST = DW'(STEP_CLKS - 1);
  localparam logic signed [SW-1:0] S_TOP = SW'(STEPS);
  localparam logic signed [SW-1:0] S_BOT = -SW'(STEPS);

  logic [CW-1:0] cnt, per_q, nxt_per, duty_lim, nom_sel, dev_sel;
  logic [DW-1:0] div_q;
  logic signed [SW-1:0] step_q;
  logic signed [WW-1:0] prod, offs, per_s;
  logic term_q, dir_dn, wrap;

  assign nom_sel = hi_sel ? CW'(NOM_HI) : CW'(NOM_LO);
  assign dev_sel = hi_sel ? CW'(DEV_HI) : CW'(DEV_LO);

  always_comb begin
    prod    = WW'(step_q) * WW'(signed'({1'b0, dev_sel}));
    offs    = prod >>> STEP_LOG2;
    per_s   = WW'(signed'({1'b0, nom_sel})) + offs;
    nxt_per = CW'(per_s);
  end

  assign wrap        = (cnt == per_q - 1'b1);
  assign duty_lim    = CW'((32'(per_q) * DUTY_PCT) / 100);
  assign cycle_start = en & (cnt == '0);
  assign gate        = en & (cnt < duty_lim) & ((cnt < TON_C) | ~term_q);
  assign off_time    = ~gate;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      per_q  <= CW'(NOM_LO);
      term_q <= 1'b0;
      div_q  <= '0;
      step_q <= '0;
      dir_dn <= 1'b0;
    end else if (!en) begin
      cnt    <= '0;
      per_q  <= nxt_per;
      term_q <= 1'b0;
      div_q  <= '0;
      step_q <= '0;
      dir_dn <= 1'b0;
    end else begin
      if (wrap) begin
        cnt    <= '0;
        per_q  <= nxt_per;
        term_q <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (cmp_trip && cnt >= LEB_C) term_q <= 1'b1;
      end
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (!dir_dn) begin
          step_q <= step_q + SW'(1);
          if (step_q == S_TOP - SW'(1)) dir_dn <= 1'b1;
        end else begin
          step_q <= step_q - SW'(1);
          if (step_q == S_BOT + SW'(1)) dir_dn <= 1'b0;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  p_period_range_r2: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |->
      (hi_sel ? (per_q >= CW'(NOM_HI - DEV_HI) && per_q <= CW'(NOM_HI + DEV_HI))
              : (per_q >= CW'(NOM_LO - DEV_LO) && per_q <= CW'(NOM_LO + DEV_LO))))
    else $error("period outside sweep range");

  p_step_range_r2: assert property (@(posedge clk) disable iff (rst)
    (step_q >= S_BOT && step_q <= S_TOP))
    else $error("sweep step outside range");

  p_period_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !cycle_start) |-> $stable(per_q))
    else $error("period changed inside a cycle");

  p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
    cycle_start |=> !cycle_start)
    else $error("start strobe longer than one clock");

  p_gate_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> cycle_start)
    else $error("gate rose outside a cycle start");

  p_min_on_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(gate) && $past(en) && en && ($past(cnt) < TON_C - 1'b1) && (TON_C <= duty_lim))
      |-> gate)
    else $error("minimum on-time violated");

  p_disabled_hold_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!en) |-> (cnt == '0 && step_q == '0))
    else $error("counter moved while disabled");
endmodule

// File: tb/jitter_pwm_gen_tb.sv
`timescale 1ns/1ps
module jitter_pwm_gen_tb;
  localparam int CLK_HZ = 50_000_000;
  localparam int NOM_LO = CLK_HZ / 60_000;
  localparam int NOM_HI = CLK_HZ / 115_000;
  localparam int DEV_LO = (NOM_LO * 4_000) / 60_000;
  localparam int DEV_HI = (NOM_HI * 8_000) / 115_000;
  localparam int LEB    = (300 * (CLK_HZ / 1000)) / 1_000_000;
  localparam int TMIN   = (400 * (CLK_HZ / 1000)) / 1_000_000;
  localparam int NV     = 12;
  // columns: trip index (-1 none), variant, uncapped on-time (0 = duty limit)
  localparam int V_TRIP[NV] = '{-1, 0, 5, 14, 15, 19, 20, 100, 650, 15, 200, 400};
  localparam int V_SEL [NV] = '{ 0, 0, 0,  0,  0,  0,  0,   0,   0,  1,   1,   1};
  localparam int V_EXP [NV] = '{ 0, 0, 0,  0, 20, 20, 21, 101, 651, 20, 201, 401};

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, hi_sel = 1'b0, cmp_trip = 1'b0;
  logic gate, cycle_start, off_time;
  int checks = 0, errors = 0;

  jitter_pwm_gen #(.MOD_HZ(2500)) u_dut (
    .clk(clk), .rst(rst), .en(en), .hi_sel(hi_sel), .cmp_trip(cmp_trip),
    .gate(gate), .cycle_start(cycle_start), .off_time(off_time));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic restart(input logic sel);
    en = 1'b0;
    hi_sel = sel;
    repeat (4) tick();
    en = 1'b1;
    #1;
  endtask

  task automatic measure(input int trip, output int per, output int on_n, output int bad_off);
    int k;
    while (!cycle_start) tick();
    k = 0; on_n = 0; bad_off = 0;
    forever begin
      if (gate) on_n++;
      if (off_time == gate) bad_off++;
      cmp_trip = (k == trip);
      tick();
      k++;
      if (cycle_start) break;
    end
    cmp_trip = 1'b0;
    per = k;
  endtask

  task automatic sweep(input logic sel, input int n, input int nom, input int dev);
    int per, on_n, bad, pmin, pmax, prev, worst;
    restart(sel);
    pmin = 1 << 30; pmax = 0; prev = -1; worst = 0;
    for (int i = 0; i < n; i++) begin
      measure(-1, per, on_n, bad);
      if (per < pmin) pmin = per;
      if (per > pmax) pmax = per;
      if (prev >= 0 && (per - prev > worst || prev - per > worst))
        worst = (per > prev) ? per - prev : prev - per;
      prev = per;
    end
    check(pmin >= nom - dev, "R2 period lower bound", pmin, nom - dev);
    check(pmax <= nom + dev, "R2 period upper bound", pmax, nom + dev);
    check(pmin <= nom - dev / 2, "R2 sweep reaches low end", pmin, nom - dev / 2);
    check(pmax >= nom + dev / 2, "R2 sweep reaches high end", pmax, nom + dev / 2);
    check(worst <= dev / 4 + 2, "R3 cycle-to-cycle step", worst, dev / 4 + 2);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per, on_n, bad, cap, exp_on, bad_dis;
    repeat (5) tick();
    check(gate == 1'b0, "R9 gate low in reset", gate, 0);
    check(cycle_start == 1'b0, "R4 no strobe in reset", cycle_start, 0);
    check(off_time == 1'b1, "R10 off flag in reset", off_time, 1);
    rst = 1'b0;
    tick();

    // R1 and R9: first cycle after enable
    restart(1'b0);
    check(cycle_start && gate, "R9 start on enable rise", {cycle_start, gate}, 3);
    measure(-1, per, on_n, bad);
    check(per == NOM_LO, "R1 low nominal period", per, NOM_LO);
    restart(1'b1);
    measure(-1, per, on_n, bad);
    check(per == NOM_HI, "R1 high nominal period", per, NOM_HI);

    // vector table: R5 R6 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      restart(V_SEL[v][0]);
      measure(-1, per, on_n, bad);
      measure(V_TRIP[v], per, on_n, bad);
      cap = (per * 80) / 100;
      exp_on = (V_EXP[v] == 0 || V_EXP[v] > cap) ? cap : V_EXP[v];
      check(on_n == exp_on, $sformatf("R5/R6/R7/R8 vector %0d on-time", v), on_n, exp_on);
      check(bad == 0, "R10 off flag inverse of gate", bad, 0);
    end

    // R9: disable mid on-time, comparator activity ignored
    restart(1'b0);
    repeat (3) tick();
    en = 1'b0;
    cmp_trip = 1'b1;
    #1;
    check(gate == 1'b0 && off_time == 1'b1, "R9 gate drops on disable", gate, 0);
    bad_dis = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (gate || cycle_start) bad_dis++;
    end
    check(bad_dis == 0, "R9 quiet while disabled", bad_dis, 0);
    cmp_trip = 1'b0;
    en = 1'b1;
    #1;
    check(cycle_start == 1'b1, "R9 restart strobe", cycle_start, 1);
    measure(-1, per, on_n, bad);
    check(per == NOM_LO, "R9 restart period nominal", per, NOM_LO);
    check(on_n == (NOM_LO * 80) / 100, "R5 untripped on-time", on_n, (NOM_LO * 80) / 100);

    sweep(1'b0, 40, NOM_LO, DEV_LO);
    sweep(1'b1, 50, NOM_HI, DEV_HI);

    check(LEB < TMIN, "R6 blanking shorter than minimum on-time", LEB, TMIN);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule